// File: doc/BRIEF.md
# Peripheral-to-Memory Transfer Channel with Wrapping Buffer

This block is one autonomous transfer channel. It moves data words between a peripheral port and on-chip memory without help from the processor. Each direction has its own handshake. In receive, the peripheral offers a word and the channel writes it into memory. In transmit, the channel reads a word from memory and hands it to the peripheral. A transfer is triggered either by an external request line or by the peripheral's own status: "receive data present" for receive, or "transmit slot empty" for transmit.

Software programs the channel through a small write port. It sets a start address, a block length in words and an address stride, then writes the control register with the enable bit set. After each word the address steps by the stride and the remaining-word count drops by one.

- In block mode the channel stops after the last word.
- In wrapping mode the address returns to the start address and the count reloads, so the same buffer is refilled without end.

Each completed block sets a sticky done flag, which also drives a level interrupt. Software clears it by writing 1 to the status location.

The controller has three states:

- `S_IDLE` (channel off).
- `S_ARMED` (waiting for a trigger). A receive word moves in this state, and a transmit memory read is issued here.
- `S_FETCH` (the transmit read data is pushed to the peripheral).

The transitions are:

- `S_IDLE`→`S_ARMED` on an enable write with a non-zero length.
- `S_ARMED`→`S_FETCH` on a transmit trigger.
- `S_FETCH`→`S_ARMED` after a non-final push, or after any push in wrapping mode.
- `S_ARMED`→`S_IDLE` on the final receive word in block mode.
- `S_FETCH`→`S_IDLE` on the final transmit push in block mode.
- Any state→`S_IDLE` on a control write with enable clear.

Top module: `xfer_chan`

## Requirements
- R1: After reset the channel is idle: `busy`=0, `irq`=0, and `mem_req`, `rx_pop` and `tx_push` are all 0.
- R2: Receive (control bit1=0): in each armed cycle with a trigger, the channel writes `rx_data` to memory at the current address (`mem_req`=1, `mem_we`=1) and asserts `rx_pop` in the same cycle.
- R3: The first word uses the start address (`cfg_addr`=0). Each later word uses the previous address plus the stride (`cfg_addr`=2), modulo 2^AW.
- R4: Transmit (control bit1=1): a trigger in the armed state issues a memory read at the current address. The next cycle pushes the returned data with `tx_push`=1, so one word moves at most every two cycles.
- R5: With control bit3=1 the trigger is `ext_req` only, and the peripheral status inputs have no effect. With bit3=0 the trigger is `rx_avail` for receive and `tx_empty` for transmit.
- R6: Block mode (control bit2=0): after the number of words in the length register (`cfg_addr`=1), `busy` falls, `irq` rises and no further words move.
- R7: Wrapping mode (control bit2=1): after the last word of a block, the address returns to the start address and the count reloads. `irq` is set at every wrap and `busy` stays 1.
- R8: `irq` is a sticky level. It clears only when 1 is written to bit0 at `cfg_addr`=4; writing 0 there leaves it unchanged.
- R9: While the channel is idle, triggers are ignored: no memory access, no pop and no push.
- R10: A control write (`cfg_addr`=3) with bit0=0 stops the channel at once without setting `irq`.
- R11: Enabling with a length of 0 moves no word, leaves the channel idle and sets `irq` immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select (0 start, 1 length, 2 stride, 3 control, 4 status) |
| cfg_wdata | input | AW | Register write data |
| busy | output | 1 | Channel enabled and not finished |
| irq | output | 1 | Block-done flag and level interrupt |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read (data one cycle later) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after a read |
| ext_req | input | 1 | External transfer request |
| rx_avail | input | 1 | Peripheral holds a received word |
| rx_data | input | DW | Received word |
| rx_pop | output | 1 | Receive word taken |
| tx_empty | input | 1 | Peripheral can accept a word |
| tx_push | output | 1 | Transmit word valid |
| tx_data | output | DW | Transmit word |

## Verification
A wrong address or count register shows up on `mem_addr` at the very next word. A count that is off by one moves `irq` or the fall of `busy` by one word, so it appears at the end of the first block, or at the first wrap in wrapping mode. A stuck state bit shows either as a memory access or pop while the channel is disabled, seen in the same cycle as the trigger, or as a transmit push missing in the cycle after its read. A scoreboard compares every memory write and every transmit push with the address and data predicted from the programmed start address, stride and length.

// File: rtl/xfer_chan_pkg.sv
package xfer_chan_pkg;
    typedef enum logic [1:0] {S_IDLE, S_ARMED, S_FETCH} chan_state_t;

    localparam logic [2:0] SEL_START  = 3'd0;
    localparam logic [2:0] SEL_LENGTH = 3'd1;
    localparam logic [2:0] SEL_STRIDE = 3'd2;
    localparam logic [2:0] SEL_CTRL   = 3'd3;
    localparam logic [2:0] SEL_STATUS = 3'd4;

    localparam int CB_ENABLE = 0;
    localparam int CB_TX     = 1;
    localparam int CB_WRAP   = 2;
    localparam int CB_EXT    = 3;
endpackage

// File: rtl/xfer_chan_regs.sv
module xfer_chan_regs
    import xfer_chan_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          blk_done,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] length,
    output logic [AW-1:0] stride,
    output logic          dir_tx,
    output logic          wrap_mode,
    output logic          ext_trig,
    output logic          go,
    output logic          halt,
    output logic          zero_len,
    output logic          done
);
    logic ctrl_wr;
    logic done_clr;

    assign ctrl_wr  = cfg_we && (cfg_addr == SEL_CTRL);
    assign go       = ctrl_wr && cfg_wdata[CB_ENABLE];
    assign halt     = ctrl_wr && !cfg_wdata[CB_ENABLE];
    assign zero_len = (length == '0);
    assign done_clr = cfg_we && (cfg_addr == SEL_STATUS) && cfg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_addr <= '0;
            length     <= '0;
            stride     <= '0;
            dir_tx     <= 1'b0;
            wrap_mode  <= 1'b0;
            ext_trig   <= 1'b0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                SEL_START:  start_addr <= cfg_wdata;
                SEL_LENGTH: length     <= cfg_wdata;
                SEL_STRIDE: stride     <= cfg_wdata;
                SEL_CTRL: begin
                    dir_tx    <= cfg_wdata[CB_TX];
                    wrap_mode <= cfg_wdata[CB_WRAP];
                    ext_trig  <= cfg_wdata[CB_EXT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        done <= 1'b0;
        else if (blk_done || (go && zero_len)) done <= 1'b1;
        else if (done_clr)                 done <= 1'b0;
    end

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr) |=> done);
    a_r11_zero_len_done: assert property (@(posedge clk) disable iff (!rst_n)
        (go && zero_len) |=> done);
endmodule

// File: rtl/xfer_chan_addr.sv
module xfer_chan_addr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] length,
    input  logic [AW-1:0] stride,
    output logic [AW-1:0] cur_addr,
    output logic          last
);
    logic [AW-1:0] remain;

    assign last = (remain == {{(AW-1){1'b0}}, 1'b1});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
        end else if (load || (step && last)) begin
            cur_addr <= start_addr;
            remain   <= length;
        end else if (step) begin
            cur_addr <= cur_addr + stride;
            remain   <= remain - 1'b1;
        end
    end

    a_r3_stride_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last && !load) |=> (cur_addr == $past(cur_addr) + $past(stride)));
    a_r7_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last && !load) |=> (cur_addr == $past(start_addr)));
endmodule

// File: rtl/xfer_chan_fsm.sv
module xfer_chan_fsm
    import xfer_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic halt,
    input  logic zero_len,
    input  logic dir_tx,
    input  logic wrap_mode,
    input  logic ext_trig,
    input  logic ext_req,
    input  logic rx_avail,
    input  logic tx_empty,
    input  logic last,
    output logic load,
    output logic step,
    output logic blk_done,
    output logic mem_req,
    output logic mem_we,
    output logic rx_pop,
    output logic tx_push,
    output logic busy
);
    chan_state_t state, state_nx;
    logic trig;

    assign trig = ext_trig ? ext_req : (dir_tx ? tx_empty : rx_avail);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  ;
            S_ARMED: if (trig) begin
                         if (dir_tx)                 state_nx = S_FETCH;
                         else if (last && !wrap_mode) state_nx = S_IDLE;
                     end
            S_FETCH: state_nx = (last && !wrap_mode) ? S_IDLE : S_ARMED;
            default: state_nx = S_IDLE;
        endcase
        if (halt)    state_nx = S_IDLE;
        else if (go) state_nx = zero_len ? S_IDLE : S_ARMED;
    end

    always_comb begin
        load     = go && !zero_len;
        mem_req  = (state == S_ARMED) && trig;
        mem_we   = !dir_tx;
        rx_pop   = mem_req && !dir_tx;
        tx_push  = (state == S_FETCH);
        step     = rx_pop || tx_push;
        blk_done = step && last;
        busy     = (state != S_IDLE);
    end

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !(mem_req || rx_pop || tx_push));
    a_r4_read_then_push: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !halt && !go) |=> tx_push);
    a_r2_one_word: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_pop, tx_push}));
    a_r6_block_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && !wrap_mode && !go) |=> !busy);
endmodule

// File: rtl/xfer_chan.sv
module xfer_chan
    import xfer_chan_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    output logic          busy,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          ext_req,
    input  logic          rx_avail,
    input  logic [DW-1:0] rx_data,
    output logic          rx_pop,
    input  logic          tx_empty,
    output logic          tx_push,
    output logic [DW-1:0] tx_data
);
    logic [AW-1:0] start_addr, length, stride;
    logic dir_tx, wrap_mode, ext_trig, go, halt, zero_len;
    logic load, step, blk_done, last;

    xfer_chan_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .blk_done(blk_done), .start_addr(start_addr),
        .length(length), .stride(stride), .dir_tx(dir_tx), .wrap_mode(wrap_mode),
        .ext_trig(ext_trig), .go(go), .halt(halt), .zero_len(zero_len), .done(irq)
    );

    xfer_chan_addr #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .start_addr(start_addr), .length(length), .stride(stride),
        .cur_addr(mem_addr), .last(last)
    );

    xfer_chan_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .halt(halt), .zero_len(zero_len),
        .dir_tx(dir_tx), .wrap_mode(wrap_mode), .ext_trig(ext_trig),
        .ext_req(ext_req), .rx_avail(rx_avail), .tx_empty(tx_empty), .last(last),
        .load(load), .step(step), .blk_done(blk_done), .mem_req(mem_req),
        .mem_we(mem_we), .rx_pop(rx_pop), .tx_push(tx_push), .busy(busy)
    );

    assign mem_wdata = rx_data;
    assign tx_data   = mem_rdata;
endmodule

// File: tb/test_xfer_chan.sv
module test_xfer_chan;
    localparam int AW = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic busy, irq, mem_req, mem_we, rx_pop, tx_push;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, tx_data;
    logic [DW-1:0] mem_rdata = '0;
    logic ext_req = 1'b0, rx_avail = 1'b0, tx_empty = 1'b0;
    logic [DW-1:0] rx_data = '0;

    int checks = 0;
    int errors = 0;
    int wr_seen = 0;
    int cyc = 0;
    logic [AW+DW-1:0] exp_wr[$];
    logic [DW-1:0] exp_tx[$];

    always #2.5 clk = ~clk;

    xfer_chan #(.AW(AW), .DW(DW)) i_xfer_chan (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .busy(busy), .irq(irq), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .ext_req(ext_req), .rx_avail(rx_avail),
        .rx_data(rx_data), .rx_pop(rx_pop), .tx_empty(tx_empty),
        .tx_push(tx_push), .tx_data(tx_data)
    );

    function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
        return {a, 8'h5A};
    endfunction

    // memory model: one-cycle read latency
    always @(posedge clk)
        if (mem_req && !mem_we) mem_rdata <= mem_word(mem_addr);

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_we) begin
            wr_seen++;
            if (exp_wr.size() == 0) check(0, "R9 unexpected write", int'(mem_addr), 0);
            else begin
                logic [AW+DW-1:0] e;
                e = exp_wr.pop_front();
                check({mem_addr, mem_wdata} == e && rx_pop, "R2/R3 rx write",
                      int'({mem_addr, mem_wdata}), int'(e));
            end
        end
        if (rst_n && tx_push) begin
            if (exp_tx.size() == 0) check(0, "R4 unexpected push", int'(tx_data), 0);
            else begin
                logic [DW-1:0] t;
                t = exp_tx.pop_front();
                check(tx_data == t, "R4 tx push", int'(tx_data), int'(t));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cfg_write(logic [2:0] a, logic [AW-1:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // driver: one word per cycle (gap adds idle cycles), pushes expectations
    task automatic rx_burst(int n, int sa, int len, int strd, int gap);
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] a;
            a = AW'(sa + (i % len) * strd);
            rx_data = DW'(16'hC000 + i * 3 + sa);
            exp_wr.push_back({a, rx_data});
            rx_avail = 1'b1;
            @(posedge clk); #1;
            rx_avail = 1'b0;
            for (int g = 0; g < gap; g++) begin @(posedge clk); #1; end
        end
    endtask

    task automatic idle_cycles(int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    initial begin
        idle_cycles(2);
        check(!busy && !irq && !mem_req && !rx_pop && !tx_push, "R1 reset state",
              int'({busy, irq, mem_req, rx_pop, tx_push}), 0);
        rst_n = 1'b1;
        idle_cycles(1);

        // R9: triggers while idle
        rx_avail = 1'b1; tx_empty = 1'b1; ext_req = 1'b1;
        idle_cycles(4);
        rx_avail = 1'b0; tx_empty = 1'b0; ext_req = 1'b0;
        check(wr_seen == 0 && !busy, "R9 idle ignores triggers", wr_seen, 0);

        // R2 R3 R6: block receive, start 10, len 4, stride 1
        cfg_write(3'd0, 8'd10); cfg_write(3'd1, 8'd4); cfg_write(3'd2, 8'd1);
        cfg_write(3'd3, 8'b0001);
        check(busy && !irq, "R6 busy after enable", int'({busy, irq}), 2);
        rx_burst(4, 10, 4, 1, 0);
        check(!busy && irq, "R6 block end", int'({busy, irq}), 1);
        rx_avail = 1'b1; idle_cycles(2); rx_avail = 1'b0;
        check(wr_seen == 4, "R6 no words after block", wr_seen, 4);

        // R8: write 0 keeps, write 1 clears
        cfg_write(3'd4, 8'd0);
        check(irq, "R8 write 0 keeps irq", irq, 1);
        cfg_write(3'd4, 8'd1);
        check(!irq, "R8 write 1 clears irq", irq, 0);

        // R3: stride 3 with gaps
        cfg_write(3'd0, 8'd200); cfg_write(3'd1, 8'd3); cfg_write(3'd2, 8'd3);
        cfg_write(3'd3, 8'b0001);
        rx_burst(3, 200, 3, 3, 2);
        check(!busy && irq && exp_wr.size() == 0, "R3 stride block", int'({busy, irq}), 1);
        cfg_write(3'd4, 8'd1);

        // R7: wrapping receive, start 40, len 3, stride 2, 7 words
        cfg_write(3'd0, 8'd40); cfg_write(3'd1, 8'd3); cfg_write(3'd2, 8'd2);
        cfg_write(3'd3, 8'b0101);
        rx_burst(3, 40, 3, 2, 0);
        check(busy && irq, "R7 irq at first wrap, still busy", int'({busy, irq}), 3);
        cfg_write(3'd4, 8'd1);
        check(!irq, "R8 clear during wrap mode", irq, 0);
        rx_burst(4, 40, 3, 2, 0);
        check(busy && irq && wr_seen == 14, "R7 second wrap", wr_seen, 14);
        cfg_write(3'd4, 8'd1);

        // R10: stop without done
        cfg_write(3'd3, 8'b0100);
        check(!busy && !irq, "R10 stop, no irq", int'({busy, irq}), 0);
        rx_avail = 1'b1; idle_cycles(3); rx_avail = 1'b0;
        check(wr_seen == 14, "R10 no words after stop", wr_seen, 14);

        // R4 R3: transmit, start 100, len 3, stride 5
        cfg_write(3'd0, 8'd100); cfg_write(3'd1, 8'd3); cfg_write(3'd2, 8'd5);
        for (int i = 0; i < 3; i++) exp_tx.push_back(mem_word(AW'(100 + 5 * i)));
        tx_empty = 1'b1;
        cfg_write(3'd3, 8'b0011);
        for (int i = 0; i < 20 && busy; i++) idle_cycles(1);
        tx_empty = 1'b0;
        check(exp_tx.size() == 0 && irq && !busy, "R4 transmit block", exp_tx.size(), 0);
        cfg_write(3'd4, 8'd1);

        // R5: external trigger; status inputs have no effect
        cfg_write(3'd0, 8'd60); cfg_write(3'd1, 8'd2); cfg_write(3'd2, 8'd1);
        cfg_write(3'd3, 8'b1001);
        rx_avail = 1'b1; rx_data = 16'h7777; idle_cycles(3);
        check(wr_seen == 14 && busy, "R5 status ignored in ext mode", wr_seen, 14);
        for (int i = 0; i < 2; i++) begin
            rx_data = DW'(16'h3100 + i);
            exp_wr.push_back({AW'(60 + i), rx_data});
            ext_req = 1'b1;
            idle_cycles(1);
        end
        ext_req = 1'b0; rx_avail = 1'b0;
        check(!busy && irq && wr_seen == 16, "R5 ext trigger block", wr_seen, 16);
        cfg_write(3'd4, 8'd1);

        // R11: zero length
        cfg_write(3'd1, 8'd0);
        cfg_write(3'd3, 8'b0001);
        check(!busy && irq, "R11 zero length", int'({busy, irq}), 1);
        rx_avail = 1'b1; idle_cycles(2); rx_avail = 1'b0;
        check(wr_seen == 16, "R11 no words moved", wr_seen, 16);

        check(exp_wr.size() == 0 && exp_tx.size() == 0, "R2 scoreboard drained",
              exp_wr.size() + exp_tx.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule